// File: doc/BRIEF.md
# I2C Controller Interrupt Aggregator

This block collects the interrupt sources of an I2C controller that can act as bus host or bus target. It holds them in three views: a per-source state vector, a software enable mask and a test-force write. Each source is one of two kinds.

A *level* source mirrors a live condition. These conditions are FIFO fill levels compared against programmable thresholds, a set of controller halt reasons, and target-side clock-stretch flags. Software cannot clear a level source; it drops only when the condition goes away. An *event* source latches a one-cycle pulse and holds it until software writes a one to that bit. A single interrupt line reports whether any enabled source is active.

The bus state machine, the FIFOs and the register-bus decode sit outside the block. They supply the fill levels, thresholds, condition flags and event pulses, and three write strobes that share one data word.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst` is high, every event bit and every enable bit is cleared on each clock edge. After reset, `irq_line` stays low until an enable bit is written, even if a level source is active.
- R2: Bit 0 of `irq_state` is high in the same cycle that `cmdq_lvl < cmdq_lo_thr`. Bit 11 is high in the same cycle that `tx_lvl < tx_lo_thr`. Neither is high when the level equals its threshold.
- R3: Bit 1 of `irq_state` is high in the same cycle that `rx_lvl > rx_hi_thr`. Bit 2 is high in the same cycle that `capt_lvl > capt_hi_thr`. Neither is high when the level equals its threshold.
- R4: If `rx_push` is high in a cycle where `rx_lvl >= RX_DEPTH`, event bit 3 is set from the next cycle on. A push at a lower level does not set it.
- R5: Bit 4 of `irq_state` is high whenever any bit of `halt_reasons` is high. It drops in the same cycle that all halt reasons are zero.
- R6: Bit 10 follows `tgt_read_stretch` and bit 12 follows `capt_stretch`, in the same cycle.
- R7: A one-cycle pulse on an `evt_in` bit sets an event bit from the next cycle on, and the bit stays set until it is cleared. The mapping is `evt_in[0..6]` to state bits 5, 6, 7, 8, 9, 13, 14.
- R8: When `clr_we` is high, each event bit whose `wdata` bit is one is cleared on the next edge. A new set of the same bit in that cycle wins over the clear. `clr_we` has no effect on level bits.
- R9: When `test_we` is high, each event bit whose `wdata` bit is one is set from the next cycle on. Each level bit whose `wdata` bit is one reads high only during that cycle.
- R10: When `enable_we` is high, the enable mask is loaded from `wdata`. `irq_line` equals the OR of (`irq_state` AND enable mask) in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdq_lvl | input | LVL_W | Host command queue fill level |
| cmdq_lo_thr | input | LVL_W | Low threshold for command queue |
| rx_lvl | input | LVL_W | Host receive FIFO fill level |
| rx_hi_thr | input | LVL_W | High threshold for receive FIFO |
| tx_lvl | input | LVL_W | Target transmit FIFO fill level |
| tx_lo_thr | input | LVL_W | Low threshold for transmit FIFO |
| capt_lvl | input | LVL_W | Target capture FIFO fill level |
| capt_hi_thr | input | LVL_W | High threshold for capture FIFO |
| rx_push | input | 1 | Write attempt into the receive FIFO |
| halt_reasons | input | HALT_W | Controller halt reason bits |
| tgt_read_stretch | input | 1 | Target stretching clock for a read |
| capt_stretch | input | 1 | Target stretching clock on full capture FIFO or zero ACK budget |
| evt_in | input | 7 | One-cycle event pulses (mapping in R7) |
| clr_we | input | 1 | Write-one-to-clear strobe for state |
| enable_we | input | 1 | Enable mask write strobe |
| test_we | input | 1 | Test-force write strobe |
| wdata | input | 15 | Write data shared by the three strobes |
| irq_state | output | 15 | Per-source interrupt state |
| irq_line | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that event pulses and overflow pushes are latched on the next cycle, that a latched event holds until cleared, that a clear with no competing set takes effect, that the halt bit follows its reason bits, and that the interrupt line never rises with an all-zero state. Several behaviours can only be shown by the bench scenarios. These are the threshold boundaries where the level equals the threshold, the rule that a set wins over a clear in the same cycle, the one-cycle lifetime of a forced level bit, clears that leave level bits untouched, and the enable mask that reset leaves at zero.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int N_SRC   = 15;
    localparam int N_PULSE = 7;

    typedef logic [N_SRC-1:0]   src_vec_t;
    typedef logic [N_PULSE-1:0] pulse_vec_t;

    typedef enum logic [3:0] {
        SRC_CMDQ_LOW    = 4'd0,
        SRC_RX_HIGH     = 4'd1,
        SRC_CAPT_HIGH   = 4'd2,
        SRC_RX_OVF      = 4'd3,
        SRC_HALTED      = 4'd4,
        SRC_SCL_CLASH   = 4'd5,
        SRC_SDA_CLASH   = 4'd6,
        SRC_STRETCH_TMO = 4'd7,
        SRC_SDA_WOBBLE  = 4'd8,
        SRC_XFER_DONE   = 4'd9,
        SRC_RD_STALL    = 4'd10,
        SRC_TX_LOW      = 4'd11,
        SRC_CAPT_STALL  = 4'd12,
        SRC_EARLY_STOP  = 4'd13,
        SRC_HOST_SILENT = 4'd14
    } src_e;

    // Level-type sources: 0,1,2,4,10,11,12
    localparam src_vec_t LEVEL_MASK = 15'h1C17;
    localparam src_vec_t EVENT_MASK = ~LEVEL_MASK;

    typedef struct packed {
        logic cmdq_low;
        logic rx_high;
        logic tx_low;
        logic capt_high;
    } fifo_flags_t;

    function automatic src_vec_t place_pulses(pulse_vec_t p);
        src_vec_t v;
        v = '0;
        v[SRC_SCL_CLASH]   = p[0];
        v[SRC_SDA_CLASH]   = p[1];
        v[SRC_STRETCH_TMO] = p[2];
        v[SRC_SDA_WOBBLE]  = p[3];
        v[SRC_XFER_DONE]   = p[4];
        v[SRC_EARLY_STOP]  = p[5];
        v[SRC_HOST_SILENT] = p[6];
        return v;
    endfunction

endpackage

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
    parameter int W     = 7,
    parameter bit ABOVE = 1'b1
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] thr,
    output logic         hit
);
    generate
        if (ABOVE) begin : g_above
            assign hit = (lvl > thr);
        end else begin : g_below
            assign hit = (lvl < thr);
        end
    endgenerate
endmodule

// File: rtl/irq_status_eval.sv
module irq_status_eval
    import i2c_irq_pkg::*;
#(
    parameter int LVL_W  = 7,
    parameter int HALT_W = 4
) (
    input  logic [LVL_W-1:0]  cmdq_lvl,
    input  logic [LVL_W-1:0]  cmdq_lo_thr,
    input  logic [LVL_W-1:0]  rx_lvl,
    input  logic [LVL_W-1:0]  rx_hi_thr,
    input  logic [LVL_W-1:0]  tx_lvl,
    input  logic [LVL_W-1:0]  tx_lo_thr,
    input  logic [LVL_W-1:0]  capt_lvl,
    input  logic [LVL_W-1:0]  capt_hi_thr,
    input  logic [HALT_W-1:0] halt_reasons,
    input  logic              tgt_read_stretch,
    input  logic              capt_stretch,
    output src_vec_t          live
);
    fifo_flags_t ff;

    irq_level_cmp #(.W(LVL_W), .ABOVE(1'b0)) u_cmdq (
        .lvl(cmdq_lvl), .thr(cmdq_lo_thr), .hit(ff.cmdq_low));
    irq_level_cmp #(.W(LVL_W), .ABOVE(1'b1)) u_rx (
        .lvl(rx_lvl), .thr(rx_hi_thr), .hit(ff.rx_high));
    irq_level_cmp #(.W(LVL_W), .ABOVE(1'b0)) u_tx (
        .lvl(tx_lvl), .thr(tx_lo_thr), .hit(ff.tx_low));
    irq_level_cmp #(.W(LVL_W), .ABOVE(1'b1)) u_capt (
        .lvl(capt_lvl), .thr(capt_hi_thr), .hit(ff.capt_high));

    always_comb begin
        live                 = '0;
        live[SRC_CMDQ_LOW]   = ff.cmdq_low;
        live[SRC_RX_HIGH]    = ff.rx_high;
        live[SRC_CAPT_HIGH]  = ff.capt_high;
        live[SRC_TX_LOW]     = ff.tx_low;
        live[SRC_HALTED]     = |halt_reasons;
        live[SRC_RD_STALL]   = tgt_read_stretch;
        live[SRC_CAPT_STALL] = capt_stretch;
    end
endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank
    import i2c_irq_pkg::*;
#(
    parameter src_vec_t MASK = EVENT_MASK
) (
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_vec,
    input  src_vec_t clr_vec,
    output src_vec_t held
);
    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_bit
            if (MASK[i]) begin : g_latch
                logic q;
                always_ff @(posedge clk) begin
                    if (rst)
                        q <= 1'b0;
                    else if (set_vec[i])
                        q <= 1'b1;
                    else if (clr_vec[i])
                        q <= 1'b0;
                end
                assign held[i] = q;
            end else begin : g_none
                assign held[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import i2c_irq_pkg::*;
#(
    parameter int LVL_W    = 7,
    parameter int RX_DEPTH = 64,
    parameter int HALT_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  cmdq_lvl,
    input  logic [LVL_W-1:0]  cmdq_lo_thr,
    input  logic [LVL_W-1:0]  rx_lvl,
    input  logic [LVL_W-1:0]  rx_hi_thr,
    input  logic [LVL_W-1:0]  tx_lvl,
    input  logic [LVL_W-1:0]  tx_lo_thr,
    input  logic [LVL_W-1:0]  capt_lvl,
    input  logic [LVL_W-1:0]  capt_hi_thr,
    input  logic              rx_push,
    input  logic [HALT_W-1:0] halt_reasons,
    input  logic              tgt_read_stretch,
    input  logic              capt_stretch,
    input  logic [6:0]        evt_in,
    input  logic              clr_we,
    input  logic              enable_we,
    input  logic              test_we,
    input  logic [14:0]       wdata,
    output logic [14:0]       irq_state,
    output logic              irq_line
);
    localparam logic [LVL_W-1:0] RX_FULL_LVL = LVL_W'(RX_DEPTH);

    src_vec_t live_vec;
    src_vec_t held_vec;
    src_vec_t set_vec;
    src_vec_t clr_vec;
    src_vec_t force_vec;
    src_vec_t en_q;
    logic     ovf_hit;

    irq_status_eval #(.LVL_W(LVL_W), .HALT_W(HALT_W)) u_status (
        .cmdq_lvl         (cmdq_lvl),
        .cmdq_lo_thr      (cmdq_lo_thr),
        .rx_lvl           (rx_lvl),
        .rx_hi_thr        (rx_hi_thr),
        .tx_lvl           (tx_lvl),
        .tx_lo_thr        (tx_lo_thr),
        .capt_lvl         (capt_lvl),
        .capt_hi_thr      (capt_hi_thr),
        .halt_reasons     (halt_reasons),
        .tgt_read_stretch (tgt_read_stretch),
        .capt_stretch     (capt_stretch),
        .live             (live_vec)
    );

    always_comb begin
        force_vec           = test_we ? src_vec_t'(wdata) : '0;
        clr_vec             = clr_we  ? src_vec_t'(wdata) : '0;
        ovf_hit             = rx_push && (rx_lvl >= RX_FULL_LVL);
        set_vec             = place_pulses(evt_in) | (force_vec & EVENT_MASK);
        set_vec[SRC_RX_OVF] = set_vec[SRC_RX_OVF] | ovf_hit;
    end

    irq_event_bank #(.MASK(EVENT_MASK)) u_events (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .held    (held_vec)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (enable_we)
            en_q <= src_vec_t'(wdata);
    end

    assign irq_state = held_vec | ((live_vec | force_vec) & LEVEL_MASK);
    assign irq_line  = |(irq_state & en_q);

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import i2c_irq_pkg::*;
#(
    parameter int LVL_W    = 7,
    parameter int RX_DEPTH = 64,
    parameter int HALT_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [LVL_W-1:0]  rx_lvl,
    input logic              rx_push,
    input logic [HALT_W-1:0] halt_reasons,
    input logic [6:0]        evt_in,
    input logic              clr_we,
    input logic              test_we,
    input logic [14:0]       wdata,
    input logic [14:0]       irq_state,
    input logic              irq_line
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(RX_DEPTH);

    assert_overflow_latch_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_lvl >= FULL_LVL) |=> irq_state[SRC_RX_OVF]);

    assert_halt_follows_R5: assert property (@(posedge clk) disable iff (rst)
        !test_we |-> (irq_state[SRC_HALTED] == (|halt_reasons)));

    assert_pulse_latch_R7: assert property (@(posedge clk) disable iff (rst)
        evt_in[0] |=> irq_state[SRC_SCL_CLASH]);

    assert_event_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_state[SRC_XFER_DONE] && !(clr_we && wdata[SRC_XFER_DONE]))
        |=> irq_state[SRC_XFER_DONE]);

    assert_event_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_we && wdata[SRC_XFER_DONE] && !evt_in[4] && !(test_we && wdata[SRC_XFER_DONE]))
        |=> !irq_state[SRC_XFER_DONE]);

    assert_test_sets_event_R9: assert property (@(posedge clk) disable iff (rst)
        (test_we && wdata[SRC_HOST_SILENT]) |=> irq_state[SRC_HOST_SILENT]);

    assert_line_needs_state_R10: assert property (@(posedge clk) disable iff (rst)
        irq_line |-> (irq_state != '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .LVL_W(LVL_W), .RX_DEPTH(RX_DEPTH), .HALT_W(HALT_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .rx_lvl       (rx_lvl),
    .rx_push      (rx_push),
    .halt_reasons (halt_reasons),
    .evt_in       (evt_in),
    .clr_we       (clr_we),
    .test_we      (test_we),
    .wdata        (wdata),
    .irq_state    (irq_state),
    .irq_line     (irq_line)
);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
    localparam int LVL_W    = 7;
    localparam int RX_DEPTH = 64;
    localparam int HALT_W   = 4;
    localparam logic [14:0] LVL_M = 15'h1C17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LVL_W-1:0] cmdq_lvl = '0, cmdq_lo_thr = '0, rx_lvl = '0, rx_hi_thr = '0;
    logic [LVL_W-1:0] tx_lvl = '0, tx_lo_thr = '0, capt_lvl = '0, capt_hi_thr = '0;
    logic rx_push = 1'b0;
    logic [HALT_W-1:0] halt_reasons = '0;
    logic tgt_read_stretch = 1'b0, capt_stretch = 1'b0;
    logic [6:0] evt_in = '0;
    logic clr_we = 1'b0, enable_we = 1'b0, test_we = 1'b0;
    logic [14:0] wdata = '0;
    logic [14:0] irq_state;
    logic irq_line;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [14:0] m_ev = '0;
    logic [14:0] m_en = '0;

    string       tag_q[$];
    logic [14:0] st_q[$];
    logic        ln_q[$];

    always #2 clk = ~clk;

    irq_aggregator #(.LVL_W(LVL_W), .RX_DEPTH(RX_DEPTH), .HALT_W(HALT_W)) dut_i (
        .clk(clk), .rst(rst),
        .cmdq_lvl(cmdq_lvl), .cmdq_lo_thr(cmdq_lo_thr),
        .rx_lvl(rx_lvl), .rx_hi_thr(rx_hi_thr),
        .tx_lvl(tx_lvl), .tx_lo_thr(tx_lo_thr),
        .capt_lvl(capt_lvl), .capt_hi_thr(capt_hi_thr),
        .rx_push(rx_push), .halt_reasons(halt_reasons),
        .tgt_read_stretch(tgt_read_stretch), .capt_stretch(capt_stretch),
        .evt_in(evt_in), .clr_we(clr_we), .enable_we(enable_we), .test_we(test_we),
        .wdata(wdata), .irq_state(irq_state), .irq_line(irq_line)
    );

    function automatic logic [14:0] live_exp();
        logic [14:0] v;
        v = '0;
        v[0]  = cmdq_lvl < cmdq_lo_thr;
        v[1]  = rx_lvl > rx_hi_thr;
        v[2]  = capt_lvl > capt_hi_thr;
        v[4]  = |halt_reasons;
        v[10] = tgt_read_stretch;
        v[11] = tx_lvl < tx_lo_thr;
        v[12] = capt_stretch;
        return v;
    endfunction

    function automatic logic [14:0] pulse_exp(logic [6:0] p);
        int pos[7] = '{5, 6, 7, 8, 9, 13, 14};
        logic [14:0] v;
        v = '0;
        for (int k = 0; k < 7; k++) v[pos[k]] = p[k];
        return v;
    endfunction

    // Driver: queue the expected outputs for the current inputs, then
    // advance one edge, update the model and drop the one-cycle strobes.
    task automatic tick(string tag);
        logic [14:0] st;
        logic [14:0] setv;
        logic [14:0] clrv;
        st = m_ev | ((live_exp() | (test_we ? wdata : 15'h0)) & LVL_M);
        tag_q.push_back(tag);
        st_q.push_back(st);
        ln_q.push_back(|(st & m_en));
        @(posedge clk);
        if (rst) begin
            m_ev = '0;
            m_en = '0;
        end else begin
            clrv = clr_we ? wdata : 15'h0;
            setv = pulse_exp(evt_in) | ((test_we ? wdata : 15'h0) & ~LVL_M);
            if (rx_push && rx_lvl >= LVL_W'(RX_DEPTH)) setv[3] = 1'b1;
            m_ev = (m_ev & ~clrv) | setv;
            if (enable_we) m_en = wdata;
        end
        #1;
        evt_in = '0; rx_push = 1'b0; clr_we = 1'b0; enable_we = 1'b0; test_we = 1'b0;
    endtask

    // Monitor: pops expected items and compares away from the clock edge
    always @(negedge clk) begin
        while (st_q.size() > 0) begin
            string t;
            logic [14:0] es;
            logic el;
            t  = tag_q.pop_front();
            es = st_q.pop_front();
            el = ln_q.pop_front();
            checks++;
            if (irq_state !== es || irq_line !== el) begin
                errors++;
                $display("FAIL %s: state=%h line=%b expected state=%h line=%b",
                         t, irq_state, irq_line, es, el);
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        // R1: strobes during reset leave nothing behind
        enable_we = 1'b1; wdata = 15'h7FFF; evt_in = 7'h7F;
        tick("R1 reset with strobes");
        tick("R1 reset idle");
        rst = 1'b0;
        tick("R1 after reset");
        cmdq_lo_thr = 7'd8; cmdq_lvl = 7'd3;
        tick("R1 enables zero after reset");

        // R2 boundaries
        cmdq_lvl = 7'd8;  tick("R2 cmdq at threshold");
        cmdq_lvl = 7'd7;  tick("R2 cmdq below threshold");
        cmdq_lvl = 7'd20;
        tx_lo_thr = 7'd4; tx_lvl = 7'd4; tick("R2 tx at threshold");
        tx_lvl = 7'd3;    tick("R2 tx below threshold");
        tx_lvl = 7'd9;

        // R3 boundaries
        rx_hi_thr = 7'd10; rx_lvl = 7'd10; tick("R3 rx at threshold");
        rx_lvl = 7'd11;    tick("R3 rx above threshold");
        capt_hi_thr = 7'd5; capt_lvl = 7'd5; tick("R3 capt at threshold");
        capt_lvl = 7'd6;    tick("R3 capt above threshold");
        capt_lvl = 7'd0; rx_lvl = 7'd0;

        // R4 overflow
        rx_hi_thr = 7'd127;
        rx_lvl = 7'd63; rx_push = 1'b1; tick("R4 push below full");
        tick("R4 no latch after partial push");
        rx_lvl = 7'd64; rx_push = 1'b1; tick("R4 push at full");
        tick("R4 overflow latched");
        clr_we = 1'b1; wdata = 15'h0008; tick("R8 clear overflow");
        tick("R8 overflow cleared");
        rx_lvl = 7'd0;

        // R5 halt reasons
        halt_reasons = 4'b0010; tick("R5 halt single reason");
        halt_reasons = 4'b1010; tick("R5 halt two reasons");
        halt_reasons = 4'b0000; tick("R5 halt released");

        // R6 stretch statuses
        tgt_read_stretch = 1'b1; tick("R6 read stretch");
        tgt_read_stretch = 1'b0; capt_stretch = 1'b1; tick("R6 capture stretch");
        capt_stretch = 1'b0; tick("R6 stretch released");

        // R7 each pulse input
        for (int k = 0; k < 7; k++) begin
            evt_in = 7'(1 << k);
            tick("R7 pulse sample");
            tick("R7 pulse latched");
        end
        tick("R7 all events held");

        // R8 clear behaviour
        cmdq_lvl = 7'd2;
        clr_we = 1'b1; wdata = 15'h7FFF; evt_in = 7'h10;
        tick("R8 clear all with competing set");
        tick("R8 set wins, level bit unaffected");
        clr_we = 1'b1; wdata = 15'h0200; tick("R8 clear remaining");
        tick("R8 all events cleared");
        cmdq_lvl = 7'd20;

        // R9 test force
        test_we = 1'b1; wdata = 15'h4800; tick("R9 force event and level");
        tick("R9 level force gone, event held");
        clr_we = 1'b1; wdata = 15'h4000; tick("R9 clear forced event");
        tick("R9 forced event cleared");

        // R10 enable mask
        enable_we = 1'b1; wdata = 15'h0010; tick("R10 write enable");
        tick("R10 disabled source idle");
        halt_reasons = 4'b0001; tick("R10 enabled source raises line");
        evt_in = 7'h01; tick("R10 unenabled event");
        tick("R10 unenabled event no line change");
        halt_reasons = 4'b0000; tick("R10 line drops");
        enable_we = 1'b1; wdata = 15'h0020; tick("R10 enable latched event");
        tick("R10 line from latched event");

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule